// File: doc/BRIEF.md
# Speech Sample Playback Sequencer

This block drives the read side of a 64K-word, 5-bit speech sample memory. Software picks a phrase by writing an 8-bit block number. The phrase then begins at the 16-bit address whose upper byte is that number and whose lower byte is zero, so there are 256 possible phrase starts spaced 0x100 words apart. Software starts playback by setting the busy flag. From then on the sequencer issues one memory read per sample tick. Each tick is derived from the main clock by a divider whose period depends on the selected sample rate.

Every code read back is checked before the address moves on. The all-ones code marks the end of a phrase: the sequencer drops the busy flag and stops, and the code is never passed on. Any other code is presented on the sample output with a one-cycle valid pulse, and the address then steps by one. The address rolls over from 0xFFFF to 0x0000 and playback keeps going. Software can abort at any time by clearing the busy flag. The sample decoder and converter downstream are not part of this block.

Top module: `speech_rom_seq`

## Requirements
- R1: After reset, busy_o, mem_rd_o and smp_valid_o are all low.
- R2: A busy_set_i pulse while idle raises busy_o in the next cycle. In that same cycle mem_rd_o is high with mem_addr_o equal to the block register value in bits 15:8 and zero in bits 7:0.
- R3: Each read is served by mem_data_i one cycle after mem_rd_o. A code other than 5'b11111 appears on smp_code_o with a one-cycle smp_valid_o pulse two cycles after its read strobe. Successive reads use consecutive addresses.
- R4: Reads during playback are DIV_FAST cycles apart when rate_sel_i was 0 at start (7 kHz), and DIV_SLOW cycles apart when it was 1 (5 kHz).
- R5: rate_sel_i is sampled only when playback starts. Changing it during playback leaves the read spacing unchanged.
- R6: A returned code of 5'b11111 is never output. busy_o is low two cycles after that read strobe, and no further reads follow.
- R7: After a read at 0xFFFF, the next read is at 0x0000 and playback continues.
- R8: busy_clr_i makes busy_o low in the next cycle, and no read or sample follows. If busy_clr_i and busy_set_i are high in the same cycle, the clear wins.
- R9: Writes to the block register and busy_set_i pulses during playback do not change the running address sequence.
- R10: smp_valid_o is never high while busy_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Main clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| blk_we_i | input | 1 | Write strobe for the start-block register |
| blk_data_i | input | 8 | Start-block number (upper address byte) |
| busy_set_i | input | 1 | Set busy flag: start playback |
| busy_clr_i | input | 1 | Clear busy flag: abort playback |
| busy_o | output | 1 | Playback active |
| rate_sel_i | input | 1 | Sample rate: 0 = 7 kHz, 1 = 5 kHz |
| mem_rd_o | output | 1 | Sample memory read strobe |
| mem_addr_o | output | 16 | Sample memory read address |
| mem_data_i | input | 5 | Code returned one cycle after the read strobe |
| smp_valid_o | output | 1 | Sample code valid pulse |
| smp_code_o | output | 5 | Sample code |

## Verification
The assertions assume a memory that answers each strobe exactly one cycle later and holds its data in the cycle after a read. They also assume that both divider parameters are at least 2, so that a read and the check of the previous read never fall in the same cycle. The bench memory is a registered model that updates only on a strobe. It produces data from a fixed function of the address, with all-ones replaced, except at one chosen terminator address. The bench changes the block register, the rate select and the set strobe only at the points the requirements name, and it runs with small dividers of 5 and 7 cycles.

// File: rtl/speech_seq_pkg.sv
package speech_seq_pkg;
  localparam int unsigned CODE_W = 5;
  typedef logic [CODE_W-1:0] code_t;

  // all-ones marks end of phrase
  function automatic logic is_term(code_t c);
    return &c;
  endfunction
endpackage

// File: rtl/speech_tick_gen.sv
module speech_tick_gen #(
  parameter int unsigned DIV_FAST = 500,
  parameter int unsigned DIV_SLOW = 700
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic rate_i,
  input  logic run_i,
  output logic fire_o
);
  localparam int unsigned DIV_MAX = (DIV_FAST > DIV_SLOW) ? DIV_FAST : DIV_SLOW;
  localparam int unsigned CNT_W   = (DIV_MAX > 2) ? $clog2(DIV_MAX) : 1;
  localparam logic [CNT_W-1:0] RELOAD_FAST = CNT_W'(DIV_FAST - 1);
  localparam logic [CNT_W-1:0] RELOAD_SLOW = CNT_W'(DIV_SLOW - 1);

  logic             rate_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rate_q <= 1'b0;
      cnt_q  <= '0;
    end else if (start_i) begin
      rate_q <= rate_i;
      cnt_q  <= '0;          // first read right after start
    end else if (run_i) begin
      if (cnt_q == '0) cnt_q <= rate_q ? RELOAD_SLOW : RELOAD_FAST;
      else             cnt_q <= cnt_q - 1'b1;
    end
  end

  assign fire_o = run_i && (cnt_q == '0);

  a_r4_no_back_to_back: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_o |=> !fire_o);
  a_r5_rate_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !start_i) |=> $stable(rate_q));
endmodule

// File: rtl/speech_addr_ctr.sv
module speech_addr_ctr #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned BLK_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [BLK_W-1:0]  blk_i,
  input  logic              adv_i,
  output logic [ADDR_W-1:0] addr_o
);
  localparam int unsigned OFS_W = ADDR_W - BLK_W;

  logic [ADDR_W-1:0] addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     addr_q <= '0;
    else if (load_i) addr_q <= {blk_i, {OFS_W{1'b0}}};
    else if (adv_i)  addr_q <= addr_q + 1'b1;   // natural rollover to zero
  end

  assign addr_o = addr_q;

  a_r7_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !load_i && (&addr_q)) |=> (addr_o == '0));
endmodule

// File: rtl/speech_code_chk.sv
module speech_code_chk
  import speech_seq_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  rd_i,
  input  logic  kill_i,
  input  code_t data_i,
  output logic  term_o,
  output logic  adv_o,
  output logic  smp_valid_o,
  output code_t smp_code_o
);
  logic  pend_q;
  logic  valid_q;
  code_t code_q;

  assign term_o = pend_q && is_term(data_i);
  assign adv_o  = pend_q && !kill_i && !is_term(data_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q  <= 1'b0;
      valid_q <= 1'b0;
      code_q  <= '0;
    end else begin
      pend_q  <= rd_i && !kill_i;
      valid_q <= adv_o;
      if (adv_o) code_q <= data_i;
    end
  end

  assign smp_valid_o = valid_q;
  assign smp_code_o  = code_q;

  a_r6_term_hidden: assert property (@(posedge clk_i) disable iff (!rst_ni)
    term_o |=> !smp_valid_o);
  a_r3_valid_after_pend: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smp_valid_o |-> $past(pend_q));
endmodule

// File: rtl/speech_rom_seq.sv
module speech_rom_seq
  import speech_seq_pkg::*;
#(
  parameter int unsigned ADDR_W   = 16,
  parameter int unsigned BLK_W    = 8,
  parameter int unsigned DIV_FAST = 500,
  parameter int unsigned DIV_SLOW = 700
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              blk_we_i,
  input  logic [BLK_W-1:0]  blk_data_i,
  input  logic              busy_set_i,
  input  logic              busy_clr_i,
  output logic              busy_o,
  input  logic              rate_sel_i,
  output logic              mem_rd_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic [CODE_W-1:0] mem_data_i,
  output logic              smp_valid_o,
  output logic [CODE_W-1:0] smp_code_o
);
  localparam int unsigned OFS_W = ADDR_W - BLK_W;

  logic [BLK_W-1:0] blk_q;
  logic             busy_q;
  logic             start;
  logic             fire;
  logic             term;
  logic             adv;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       blk_q <= '0;
    else if (blk_we_i) blk_q <= blk_data_i;
  end

  assign start = busy_set_i && !busy_q && !busy_clr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         busy_q <= 1'b0;
    else if (busy_clr_i) busy_q <= 1'b0;
    else if (start)      busy_q <= 1'b1;
    else if (term)       busy_q <= 1'b0;
  end

  speech_tick_gen #(
    .DIV_FAST (DIV_FAST),
    .DIV_SLOW (DIV_SLOW)
  ) u_tick (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start),
    .rate_i  (rate_sel_i),
    .run_i   (busy_q),
    .fire_o  (fire)
  );

  speech_addr_ctr #(
    .ADDR_W (ADDR_W),
    .BLK_W  (BLK_W)
  ) u_addr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (start),
    .blk_i  (blk_q),
    .adv_i  (adv),
    .addr_o (mem_addr_o)
  );

  speech_code_chk u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rd_i        (fire),
    .kill_i      (busy_clr_i),
    .data_i      (mem_data_i),
    .term_o      (term),
    .adv_o       (adv),
    .smp_valid_o (smp_valid_o),
    .smp_code_o  (smp_code_o)
  );

  assign busy_o   = busy_q;
  assign mem_rd_o = fire;

  a_r2_first_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start |=> (busy_o && mem_rd_o && mem_addr_o == {$past(blk_q), {OFS_W{1'b0}}}));
  a_r3_addr_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv |=> (mem_addr_o == ADDR_W'($past(mem_addr_o) + 1'b1)));
  a_r6_term_stops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (term && !start) |=> !busy_o);
  a_r8_clear_stops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_clr_i |=> (!busy_o && !mem_rd_o));
  a_r9_addr_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !adv && !start) |=> $stable(mem_addr_o));
  a_r10_valid_needs_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smp_valid_o |-> busy_o);
endmodule

// File: tb/sim_speech_rom_seq.sv
`timescale 1ns/1ps
module sim_speech_rom_seq;
  localparam int DF = 5;
  localparam int DS = 7;
  localparam int MAXN = 600;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        blk_we = 1'b0;
  logic [7:0]  blk_data = '0;
  logic        bset = 1'b0;
  logic        bclr = 1'b0;
  logic        busy;
  logic        rate = 1'b0;
  logic        rd;
  logic [15:0] addr;
  logic [4:0]  rdata = '0;
  logic        sv;
  logic [4:0]  scode;

  int n_chk = 0;
  int n_fail = 0;
  logic [15:0] term_a = 16'h0000;

  always #2 clk = ~clk;

  speech_rom_seq #(.DIV_FAST(DF), .DIV_SLOW(DS)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .blk_we_i(blk_we), .blk_data_i(blk_data),
    .busy_set_i(bset), .busy_clr_i(bclr), .busy_o(busy), .rate_sel_i(rate),
    .mem_rd_o(rd), .mem_addr_o(addr), .mem_data_i(rdata),
    .smp_valid_o(sv), .smp_code_o(scode)
  );

  function automatic logic [4:0] code_at(logic [15:0] a);
    logic [4:0] c;
    if (a == term_a) return 5'h1F;
    c = a[4:0] + a[10:6] + a[15:11];
    if (c == 5'h1F) c = 5'h0A;
    return c;
  endfunction

  always @(posedge clk) if (rd) rdata <= code_at(addr);

  // monitor
  int cyc = 0;
  int nrd = 0;
  int ns = 0;
  int fall_cyc = -1;
  int bad_idle = 0;
  logic busy_prev = 1'b0;
  logic [15:0] rd_addr [MAXN];
  int          rd_cyc  [MAXN];
  logic [4:0]  smp     [MAXN];

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (rd && nrd < MAXN) begin rd_addr[nrd] <= addr; rd_cyc[nrd] <= cyc; nrd <= nrd + 1; end
    if (sv && ns < MAXN) begin smp[ns] <= scode; ns <= ns + 1; end
    if (sv && !busy) bad_idle <= bad_idle + 1;
    if (busy_prev && !busy) fall_cyc <= cyc;
    busy_prev <= busy;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp_v);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp_v);
    end
  endtask

  task automatic clr_log();
    @(posedge clk); #1;
    nrd = 0; ns = 0; fall_cyc = -1;
  endtask

  task automatic write_blk(input logic [7:0] b);
    @(negedge clk); blk_we = 1'b1; blk_data = b;
    @(negedge clk); blk_we = 1'b0;
  endtask

  task automatic start_play();
    @(negedge clk); bset = 1'b1;
    @(negedge clk); bset = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 4000 && busy; i++) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  // check one finished playback
  task automatic check_run(input string tag, input logic [7:0] b, input int exp_n, input int gap);
    int bad_a = 0;
    int bad_g = 0;
    int bad_s = 0;
    chk(!busy, {tag, " R6 busy low at end"}, busy, 0);
    chk(nrd == exp_n + 1, {tag, " R6 read count"}, nrd, exp_n + 1);
    chk(nrd > 0 && rd_addr[0] == {b, 8'h00}, {tag, " R2 first address"}, rd_addr[0], {b, 8'h00});
    for (int i = 1; i < nrd; i++) begin
      if (rd_addr[i] != 16'(rd_addr[0] + 16'(i))) bad_a++;
      if (rd_cyc[i] - rd_cyc[i-1] != gap) bad_g++;
    end
    chk(bad_a == 0, {tag, " R3 consecutive addresses"}, bad_a, 0);
    chk(bad_g == 0, {tag, " R4 read spacing"}, bad_g, 0);
    chk(ns == exp_n, {tag, " R3 sample count"}, ns, exp_n);
    for (int i = 0; i < ns && i < nrd; i++) if (smp[i] != code_at(rd_addr[i])) bad_s++;
    chk(bad_s == 0, {tag, " R3 sample codes"}, bad_s, 0);
    chk(nrd > 0 && fall_cyc == rd_cyc[nrd-1] + 2, {tag, " R6 busy fall timing"},
        fall_cyc, (nrd > 0) ? rd_cyc[nrd-1] + 2 : 0);
  endtask

  task automatic t_reset();
    #1;
    chk(!busy && !rd && !sv, "R1 outputs in reset", {busy, rd, sv}, 0);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!busy && !rd && !sv, "R1 outputs after reset", {busy, rd, sv}, 0);
  endtask

  task automatic t_start_timing();
    write_blk(8'h3C); term_a = 16'h3C04; rate = 1'b0;
    clr_log();
    @(negedge clk); bset = 1'b1;
    @(negedge clk); bset = 1'b0;
    chk(busy && rd && addr == 16'h3C00, "R2 busy and first read next cycle", addr, 16'h3C00);
    @(negedge clk);
    @(negedge clk);
    chk(sv && scode == code_at(16'h3C00), "R3 sample two cycles after strobe", scode, code_at(16'h3C00));
    wait_idle();
    check_run("fast", 8'h3C, 4, DF);
  endtask

  task automatic t_slow();
    write_blk(8'h81); term_a = 16'h8109; rate = 1'b1;
    clr_log(); start_play(); rate = 1'b0;
    wait_idle();
    check_run("slow", 8'h81, 9, DS);
  endtask

  task automatic t_term_first();
    write_blk(8'h05); term_a = 16'h0500; rate = 1'b0;
    clr_log(); start_play(); wait_idle();
    check_run("term-first", 8'h05, 0, DF);
  endtask

  task automatic t_wrap();
    write_blk(8'hFF); term_a = 16'h0001; rate = 1'b0;
    clr_log(); start_play(); wait_idle();
    check_run("wrap", 8'hFF, 257, DF);
    chk(nrd > 257 && rd_addr[256] == 16'h0000, "R7 read after FFFF is 0000", rd_addr[256], 0);
  endtask

  task automatic t_mid_changes();
    write_blk(8'h42); term_a = 16'h420C; rate = 1'b0;
    clr_log(); start_play();
    repeat (13) @(negedge clk);
    rate = 1'b1; blk_we = 1'b1; blk_data = 8'h99;
    @(negedge clk); blk_we = 1'b0; bset = 1'b1;
    @(negedge clk); bset = 1'b0;
    wait_idle();
    check_run("mid-change R5 R9", 8'h42, 12, DF);
    rate = 1'b0;
  endtask

  task automatic t_abort();
    write_blk(8'h20); term_a = 16'h0000; rate = 1'b0;
    clr_log(); start_play();
    repeat (12) @(negedge clk);
    bclr = 1'b1;
    @(negedge clk); bclr = 1'b0;
    chk(!busy, "R8 busy low after clear", busy, 0);
    clr_log();
    repeat (30) @(negedge clk);
    chk(nrd == 0, "R8 no reads after clear", nrd, 0);
    chk(ns == 0, "R8 no samples after clear", ns, 0);
  endtask

  task automatic t_clear_wins();
    write_blk(8'h11); term_a = 16'h1103;
    clr_log();
    @(negedge clk); bset = 1'b1; bclr = 1'b1;
    @(negedge clk); bset = 1'b0; bclr = 1'b0;
    chk(!busy, "R8 clear beats set", busy, 0);
    repeat (20) @(negedge clk);
    chk(nrd == 0 && ns == 0, "R8 no activity after set+clear", nrd + ns, 0);
  endtask

  bit done = 1'b0;

  initial begin
    t_reset();
    t_start_timing();
    t_slow();
    t_term_first();
    t_wrap();
    t_mid_changes();
    t_abort();
    t_clear_wins();
    chk(bad_idle == 0, "R10 valid while idle", bad_idle, 0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL R6 watchdog: actual=%0d expected=%0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule